// File: doc/BRIEF.md
# Prescaled Reloadable Interval Timer Group

This block holds four 16-bit up-counting timers for a CPU subsystem. Each timer has its own reload value and control settings. A control write that sets the start flag on a stopped timer loads the counter from the reload value. From then on the counter advances either from the system clock, through a selectable divider, or once for each overflow of the next lower timer. When a counter steps past 0xFFFF it loads the reload value again, so no tick is lost. If its interrupt enable is set, it also raises a one-cycle interrupt request.

Software reaches the timers through a plain register port: a 2-bit timer index and a select bit that chooses the counter/reload pair or the control word. A read returns the live count as it stood when the read was taken. The interrupt controller that consumes the four request lines lies outside this block.

Top module: `timer_group`

## Requirements
- R1: A control write (sel=1) with bit 7 set to a stopped timer loads its counter with the reload value at that write's clock edge; the counter does not step on that same edge.
- R2: Control bits 1:0 choose the step rate: value 0, 1, 2 or 3 gives one step every 1, 64, 256 or 1024 clocks. The divider phase clears at the start edge, so the first step falls exactly one full period after it.
- R3: A control write with bit 7 set to a timer that is already running does not reload the counter.
- R4: With rd_en high, rdata on the following cycle holds, for sel=0, the counter of timer idx as it stood just before the read edge. For sel=1 it holds the control read-back: bit 7 start, bit 6 interrupt enable, bit 2 count-up, bits 1:0 rate, and all other bits zero.
- R5: A step from 0xFFFF loads the counter with the reload value, and counting continues from there.
- R6: When a timer overflows with control bit 6 set, irq[i] is high for exactly the cycle after the overflow edge. With bit 6 clear, no pulse appears.
- R7: A reload write (sel=0) to a running timer leaves the counter unchanged. The new value takes effect at the next overflow or start edge.
- R8: With control bit 2 set, a timer with index 1 to 3 steps once for each overflow of the timer one index lower, and it ignores the system clock.
- R9: Timer 0 ignores control bit 2: the bit reads back as 0, and the timer counts from the clock.
- R10: Clearing the start bit freezes the counter at its current value.
- R11: After reset, every counter, reload value, control word, rdata and irq output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 1 | 0: counter (read) / reload (write); 1: control |
| idx | input | 2 | Timer index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered, valid the cycle after rd_en |
| irq | output | 4 | Per-timer overflow interrupt pulse, registered |

## Verification
Every write takes effect on the clock edge where it is sampled. A read returns, one cycle later, the count from just before its own edge. An interrupt pulse appears in the cycle after the overflow edge. The bench drives and samples only at falling edges and advances time one edge at a time through its tasks. It therefore knows the number of the edge that lands each write and read, and it derives every expected count by counting clocks from the start edge: the reload value plus the number of elapsed edges divided by the rate, or the overflow count of the lower timer. Pulse checks sample the exact cycle after the overflow edge, and the cycle before it as well.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CTL_RUN_BIT  = 7;
  localparam int CTL_IEN_BIT  = 6;
  localparam int CTL_CASC_BIT = 2;

  typedef struct packed {
    logic       run;
    logic       ien;
    logic       casc;
    logic [1:0] rate;
  } tmr_ctl_t;

  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_CTRL  = 1'b1
  } tmr_sel_e;

  function automatic logic [7:0] ctl_to_byte(tmr_ctl_t c);
    return {c.run, c.ien, 3'b000, c.casc, c.rate};
  endfunction
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int SH1 = 6,
  parameter int SH2 = 8,
  parameter int SH3 = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int PW = SH3;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] limit;

  always_comb begin
    case (rate)
      2'd0:    limit = '0;
      2'd1:    limit = PW'((1 << SH1) - 1);
      2'd2:    limit = PW'((1 << SH2) - 1);
      default: limit = PW'((1 << SH3) - 1);
    endcase
  end

  assign tick = run && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear)
      phase_q <= '0;
    else if (run)
      phase_q <= tick ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int W       = 16,
  parameter bit CASC_OK = 1'b1,
  parameter int SH1     = 6,
  parameter int SH2     = 8,
  parameter int SH3     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_ctl,
  input  logic         wr_rld,
  input  logic [W-1:0] wdata,
  input  logic         casc_in,
  output logic         ovf,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output tmr_ctl_t     ctl
);
  tmr_ctl_t     ctl_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] rld_q;
  logic         start_edge;
  logic         tick;
  logic         inc;

  assign start_edge = wr_ctl && wdata[CTL_RUN_BIT] && !ctl_q.run;

  timer_prescaler #(.SH1(SH1), .SH2(SH2), .SH3(SH3)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clear (start_edge),
    .run   (ctl_q.run && !ctl_q.casc),
    .rate  (ctl_q.rate),
    .tick  (tick)
  );

  assign inc = ctl_q.run && (ctl_q.casc ? casc_in : tick);
  assign ovf = inc && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      rld_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.run  <= wdata[CTL_RUN_BIT];
        ctl_q.ien  <= wdata[CTL_IEN_BIT];
        ctl_q.casc <= CASC_OK ? wdata[CTL_CASC_BIT] : 1'b0;
        ctl_q.rate <= wdata[1:0];
      end
      if (wr_rld)
        rld_q <= wdata;
      if (start_edge)
        cnt_q <= rld_q;
      else if (inc)
        cnt_q <= ovf ? rld_q : cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign rld = rld_q;
  assign ctl = ctl_q;
endmodule

// File: rtl/timer_group.sv
module timer_group
  import timer_pkg::*;
#(
  parameter int N   = 4,
  parameter int W   = 16,
  parameter int SH1 = 6,
  parameter int SH2 = 8,
  parameter int SH3 = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 sel,
  input  logic [$clog2(N)-1:0] idx,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         rdata,
  output logic [N-1:0]         irq
);
  localparam int IW = $clog2(N);

  logic [N-1:0][W-1:0] cnt_all;
  logic [N-1:0][W-1:0] rld_all;
  logic [N-1:0]        ovf_all;
  logic [N-1:0]        run_all;
  logic [N-1:0]        ien_all;
  logic [N-1:0]        casc_all;
  tmr_ctl_t            ctl_all [N];
  logic [N-1:0]        irq_q;
  logic [W-1:0]        rdata_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic casc_src;
    if (i == 0) begin : g_first
      assign casc_src = 1'b0;
    end else begin : g_chain
      assign casc_src = ovf_all[i-1];
    end

    timer_channel #(
      .W(W), .CASC_OK(i != 0), .SH1(SH1), .SH2(SH2), .SH3(SH3)
    ) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_ctl  (wr_en && (sel == SEL_CTRL)  && (idx == IW'(i))),
      .wr_rld  (wr_en && (sel == SEL_COUNT) && (idx == IW'(i))),
      .wdata   (wdata),
      .casc_in (casc_src),
      .ovf     (ovf_all[i]),
      .cnt     (cnt_all[i]),
      .rld     (rld_all[i]),
      .ctl     (ctl_all[i])
    );

    assign run_all[i]  = ctl_all[i].run;
    assign ien_all[i]  = ctl_all[i].ien;
    assign casc_all[i] = ctl_all[i].casc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      rdata_q <= '0;
    end else begin
      irq_q <= ovf_all & ien_all;
      if (rd_en)
        rdata_q <= (sel == SEL_CTRL) ? W'(ctl_to_byte(ctl_all[idx])) : cnt_all[idx];
    end
  end

  assign irq   = irq_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/timer_group_chk.sv
module timer_group_chk #(
  parameter int N = 4,
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 sel,
  input logic [$clog2(N)-1:0] idx,
  input logic [W-1:0]         wdata,
  input logic [N-1:0][W-1:0]  cnt_all,
  input logic [N-1:0][W-1:0]  rld_all,
  input logic [N-1:0]         ovf_all,
  input logic [N-1:0]         run_all,
  input logic [N-1:0]         ien_all,
  input logic [N-1:0]         casc_all,
  input logic [N-1:0]         irq
);
  localparam int IW = $clog2(N);

  for (genvar i = 0; i < N; i++) begin : g_chk
    logic ctl_hit;
    assign ctl_hit = wr_en && sel && (idx == IW'(i));

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
      (ctl_hit && wdata[7] && !run_all[i]) |=> (cnt_all[i] == $past(rld_all[i]))); // R1

    AST_STEP_OR_RELOAD: assert property (@(posedge clk) disable iff (rst)
      !ctl_hit |=> ((cnt_all[i] == $past(cnt_all[i])) ||
                    (cnt_all[i] == W'($past(cnt_all[i]) + 1'b1)) ||
                    (cnt_all[i] == $past(rld_all[i])))); // R5

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!run_all[i] && !ctl_hit) |=> (cnt_all[i] == $past(cnt_all[i]))); // R10

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> $past(ovf_all[i] && ien_all[i])); // R6

    if (i == 0) begin : g_t0
      AST_T0_NO_CASC: assert property (@(posedge clk) disable iff (rst)
        !casc_all[i]); // R9
    end else begin : g_tn
      AST_CASC_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (run_all[i] && casc_all[i] && !ovf_all[i-1] && !ctl_hit)
          |=> (cnt_all[i] == $past(cnt_all[i]))); // R8
    end
  end
endmodule

bind timer_group timer_group_chk #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .sel      (sel),
  .idx      (idx),
  .wdata    (wdata),
  .cnt_all  (cnt_all),
  .rld_all  (rld_all),
  .ovf_all  (ovf_all),
  .run_all  (run_all),
  .ien_all  (ien_all),
  .casc_all (casc_all),
  .irq      (irq)
);

// File: tb/test_timer_group.sv
module test_timer_group;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        sel = 1'b0;
  logic [1:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  timer_group i_timer_group (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
    .idx(idx), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] t, logic s, logic [15:0] d);
    idx = t; sel = s; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] t, logic s, output logic [15:0] v);
    idx = t; sel = s; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    v = rdata;
  endtask

  // R11: reset state
  task automatic t_reset();
    logic [15:0] v;
    chk("R11 rdata", rdata, 16'h0);
    chk("R11 irq", {12'b0, irq}, 16'h0);
    for (int t = 0; t < 4; t++) begin
      rd(2'(t), 1'b0, v);
      chk("R11 count", v, 16'h0);
    end
    rd(2'd0, 1'b1, v);
    chk("R11 ctl", v, 16'h0);
  endtask

  // R1 R2: start load, rates, phase clear
  task automatic t_rates();
    logic [15:0] v;
    wr(2'd1, 1'b0, 16'h0000);
    wr(2'd1, 1'b1, 16'h0080);          // rate 1, start at E0
    rd(2'd1, 1'b0, v);                 // E1 -> value after E0
    chk("R1 load", v, 16'h0000);
    idle(4);                           // E2..E5
    rd(2'd1, 1'b0, v);                 // after E5
    chk("R2 rate1", v, 16'h0005);
    wr(2'd1, 1'b1, 16'h0000);
    wr(2'd1, 1'b1, 16'h0081);          // rate 64
    idle(63);
    rd(2'd1, 1'b0, v);
    chk("R2 rate64 before", v, 16'h0000);
    rd(2'd1, 1'b0, v);
    chk("R2 rate64 first", v, 16'h0001);
    idle(190);
    rd(2'd1, 1'b0, v);
    chk("R2 rate64 later", v, 16'h0003);
    wr(2'd1, 1'b1, 16'h0000);
    wr(2'd1, 1'b0, 16'h0020);
    wr(2'd1, 1'b1, 16'h0082);          // rate 256
    idle(255);
    rd(2'd1, 1'b0, v);
    chk("R2 rate256 before", v, 16'h0020);
    rd(2'd1, 1'b0, v);
    chk("R2 rate256 first", v, 16'h0021);
    wr(2'd1, 1'b1, 16'h0000);
    wr(2'd1, 1'b1, 16'h0083);          // rate 1024
    idle(1023);
    rd(2'd1, 1'b0, v);
    chk("R2 rate1024 before", v, 16'h0020);
    rd(2'd1, 1'b0, v);
    chk("R2 rate1024 first", v, 16'h0021);
    wr(2'd1, 1'b1, 16'h0000);
  endtask

  // R3 R10: restart while running, then stop
  task automatic t_restart_stop();
    logic [15:0] v;
    wr(2'd2, 1'b0, 16'h1000);
    wr(2'd2, 1'b1, 16'h0080);          // E0
    idle(9);                           // E1..E9
    wr(2'd2, 1'b1, 16'h0080);          // E10, running: no reload
    idle(4);                           // E11..E14
    rd(2'd2, 1'b0, v);                 // E15 -> after E14
    chk("R3 no reload", v, 16'h100E);
    wr(2'd2, 1'b1, 16'h0000);          // E16 still steps -> 0x1010
    idle(20);
    rd(2'd2, 1'b0, v);
    chk("R10 frozen", v, 16'h1010);
  endtask

  // R5 R6 R7: overflow, irq pulse, reload write while running
  task automatic t_overflow();
    logic [15:0] v;
    wr(2'd3, 1'b0, 16'hFFF0);
    wr(2'd3, 1'b1, 16'h00C0);          // E0: start, irq enable
    wr(2'd3, 1'b0, 16'h1234);          // E1: reload changes, count not
    idle(13);                          // E2..E14
    rd(2'd3, 1'b0, v);                 // E15 -> after E14
    chk("R7 count kept", v, 16'hFFFE);
    chk("R6 no early irq", {15'b0, irq[3]}, 16'h0);
    idle(1);                           // E16 overflow
    chk("R6 irq pulse", {15'b0, irq[3]}, 16'h1);
    chk("R6 other irq", {13'b0, irq[2:0]}, 16'h0);
    rd(2'd3, 1'b0, v);                 // E17 -> after E16
    chk("R5 reload point", v, 16'h1234);
    chk("R6 pulse ends", {15'b0, irq[3]}, 16'h0);
    idle(3);
    rd(2'd3, 1'b0, v);
    chk("R5 continues", v, 16'h1238);
    wr(2'd3, 1'b1, 16'h0000);
    wr(2'd3, 1'b0, 16'hFFFF);
    wr(2'd3, 1'b1, 16'h0080);          // E0, irq disabled
    idle(1);                           // E1 overflow
    chk("R6 masked", {15'b0, irq[3]}, 16'h0);
    idle(1);
    chk("R6 masked later", {15'b0, irq[3]}, 16'h0);
    wr(2'd3, 1'b1, 16'h0000);
  endtask

  // R8: cascade from timer 0 into timer 1
  task automatic t_cascade();
    logic [15:0] v;
    wr(2'd1, 1'b0, 16'h0010);
    wr(2'd0, 1'b0, 16'hFFFE);
    wr(2'd1, 1'b1, 16'h0084);          // cascade, start
    wr(2'd0, 1'b1, 16'h0080);          // E0
    idle(10);                          // overflows at E2,4,6,8,10
    rd(2'd1, 1'b0, v);
    chk("R8 cascade count", v, 16'h0015);
    wr(2'd0, 1'b1, 16'h0000);          // E12: timer 0 overflows once more
    idle(5);
    rd(2'd1, 1'b0, v);
    chk("R8 no clock steps", v, 16'h0016);
    wr(2'd1, 1'b1, 16'h0000);
  endtask

  // R9 R4: timer 0 count-up ignored, control read-back
  task automatic t_t0_and_readback();
    logic [15:0] v;
    wr(2'd0, 1'b0, 16'h0100);
    wr(2'd0, 1'b1, 16'h0084);          // E0
    idle(5);
    rd(2'd0, 1'b0, v);
    chk("R9 counts clock", v, 16'h0105);
    rd(2'd0, 1'b1, v);
    chk("R9 bit2 reads 0", v, 16'h0080);
    wr(2'd0, 1'b1, 16'h0000);
    wr(2'd3, 1'b1, 16'h007B);
    rd(2'd3, 1'b1, v);
    chk("R4 ctl readback", v, 16'h0043);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    step();
    t_reset();
    t_rates();
    t_restart_stop();
    t_overflow();
    t_cascade();
    t_t0_and_readback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule